// File: doc/BRIEF.md
# Nested Priority Interrupt Chain Controller

This block arbitrates interrupt requests from a chain of up to sixteen peripheral positions, numbered from 0, where a lower index means higher priority. Every position holds three flags (enable, requested, pending) and an 8-bit vector latched when its request is accepted. One level interrupt line goes to the processor. A processor acknowledge takes the highest-priority requested position into service and returns its vector. A return-from-interrupt strobe releases the innermost service level and opens the chain again, up to the next level that is still in service.

Nesting comes from the enable flags. An accepted request disables its own position and every lower-priority active position. Only positions with a higher priority can then interrupt the routine in progress. The parameter `N_ACT` sets how many positions are live. Request strobes on positions at or above that count have no effect.

Top module: `irq_daisy_chain`

## Requirements
- R1: Positions with index at or above `N_ACT` are inactive. A request strobe on them changes no state and never raises `irq_o`.
- R2: After reset every position is enabled and holds no request, no pending service and a vector of 0. `irq_o`, `ack_vec_o`, `ack_err_o` and `req_err_o` are all 0.
- R3: A request on a disabled position is dropped and changes no state.
- R4: An accepted request clears that position's enable, sets its requested flag and latches `req_vec_i[8*p +: 8]`. `irq_o` is high in the cycle after the strobe.
- R5: An accepted request on position p clears the enable of every active position with an index greater than p.
- R6: On `ack_i` the lowest-index position with requested set moves from requested to pending. Its vector appears on `ack_vec_o` in the cycle after the strobe, and `ack_err_o` stays 0.
- R7: `ack_i` while no position has requested set pulses `ack_err_o` high for the next cycle. It changes no state and `ack_vec_o` keeps its previous value.
- R8: `irq_o` is high exactly while at least one position has requested set.
- R9: On `reti_i` positions are scanned upward from index 0 and each scanned position gets its enable set. The first pending position found has its pending flag cleared. The scan stops at the next pending position, which is enabled but stays pending, and all positions above it are left untouched.
- R10: A request on a position that is enabled and still pending is dropped. `req_err_o` pulses high for the next cycle.
- R11: Within one cycle the strobes are applied in this order: return, then acknowledge, then requests in ascending index. An acceptance at a lower index disables higher positions before their requests are evaluated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 16 | Per-position request strobes, bit p for position p |
| req_vec_i | input | 128 | Request vectors, position p on bits 8*p+7 down to 8*p |
| ack_i | input | 1 | Acknowledge strobe from the processor |
| reti_i | input | 1 | Return-from-interrupt strobe |
| irq_o | output | 1 | Interrupt line to the processor (level) |
| ack_vec_o | output | 8 | Vector of the last successful acknowledge (registered) |
| ack_err_o | output | 1 | Acknowledge with nothing requested (one-cycle pulse) |
| req_err_o | output | 1 | Request to a position that is still pending (one-cycle pulse) |

## Verification
The per-position flags are visible only indirectly, so a corrupted enable or pending flag shows up later as a request that is accepted or dropped wrongly. That error reaches `irq_o` one cycle after the next request strobe on the affected position. A wrong requested flag or latched vector appears on `ack_vec_o` or `ack_err_o` one cycle after the next acknowledge. A flaw in the return scan can stay hidden for several nesting levels, because it surfaces only when a later request or acknowledge touches a position the scan should have released or kept. For that reason the bench runs long random interleavings of all three strobes against a cycle-by-cycle model, in addition to directed nesting sequences.

// File: rtl/irq_dc_pkg.sv
package irq_dc_pkg;
  localparam int unsigned MAX_POS = 16;
  localparam int unsigned VEC_W   = 8;

  typedef logic [VEC_W-1:0] vec_t;

  typedef struct packed {
    logic en;
    logic rq;
    logic pd;
    vec_t vec;
  } pos_t;
endpackage

// File: rtl/irq_dc_reti.sv
module irq_dc_reti
  import irq_dc_pkg::*;
#(
  parameter int unsigned N = MAX_POS
) (
  input  logic           reti_i,
  input  pos_t [N-1:0]   st_i,
  output pos_t [N-1:0]   st_o
);
  logic found, stop;

  always_comb begin
    st_o  = st_i;
    found = 1'b0;
    stop  = 1'b0;
    if (reti_i) begin
      for (int i = 0; i < int'(N); i++) begin
        if (!stop) begin
          st_o[i].en = 1'b1;
          if (st_i[i].pd) begin
            if (found) begin
              stop = 1'b1;  // next level stays in service
            end else begin
              st_o[i].pd = 1'b0;
              found      = 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/irq_dc_ack.sv
module irq_dc_ack
  import irq_dc_pkg::*;
#(
  parameter int unsigned N = MAX_POS
) (
  input  logic           ack_i,
  input  pos_t [N-1:0]   st_i,
  output pos_t [N-1:0]   st_o,
  output logic           hit_o,
  output logic           err_o,
  output vec_t           vec_o
);
  logic hit;

  always_comb begin
    st_o  = st_i;
    hit   = 1'b0;
    vec_o = '0;
    if (ack_i) begin
      for (int i = 0; i < int'(N); i++) begin
        if (!hit && st_i[i].rq) begin
          st_o[i].rq = 1'b0;
          st_o[i].pd = 1'b1;
          vec_o      = st_i[i].vec;
          hit        = 1'b1;
        end
      end
    end
    hit_o = hit;
    err_o = ack_i && !hit;
  end
endmodule

// File: rtl/irq_dc_req.sv
module irq_dc_req
  import irq_dc_pkg::*;
#(
  parameter int unsigned N     = MAX_POS,
  parameter int unsigned N_ACT = 8
) (
  input  logic [N-1:0]   req_i,
  input  vec_t [N-1:0]   vec_i,
  input  pos_t [N-1:0]   st_i,
  output pos_t [N-1:0]   st_o,
  output logic           err_o
);
  logic mask, err;

  always_comb begin
    st_o = st_i;
    mask = 1'b0;
    err  = 1'b0;
    for (int i = 0; i < int'(N); i++) begin
      if (i < int'(N_ACT)) begin
        if (mask) st_o[i].en = 1'b0;
        if (req_i[i] && st_o[i].en) begin
          if (st_o[i].pd) begin
            err = 1'b1;  // still in service: drop
          end else begin
            st_o[i].en  = 1'b0;
            st_o[i].rq  = 1'b1;
            st_o[i].vec = vec_i[i];
            mask        = 1'b1;
          end
        end
      end
    end
    err_o = err;
  end
endmodule

// File: rtl/irq_daisy_chain.sv
module irq_daisy_chain
  import irq_dc_pkg::*;
#(
  parameter int unsigned N_ACT = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [MAX_POS-1:0]         req_i,
  input  logic [MAX_POS*VEC_W-1:0]   req_vec_i,
  input  logic                       ack_i,
  input  logic                       reti_i,
  output logic                       irq_o,
  output logic [VEC_W-1:0]           ack_vec_o,
  output logic                       ack_err_o,
  output logic                       req_err_o
);
  localparam int unsigned N = MAX_POS;

  pos_t [N-1:0] st_q, st_reti, st_ack, st_d;
  vec_t [N-1:0] vec_in;
  logic         ack_hit, ack_err, req_err;
  vec_t         ack_vec;
  logic         any_rq;

  for (genvar g = 0; g < int'(N); g++) begin : g_vec
    assign vec_in[g] = req_vec_i[g*VEC_W +: VEC_W];
  end

  irq_dc_reti #(.N(N)) u_reti (
    .reti_i (reti_i),
    .st_i   (st_q),
    .st_o   (st_reti)
  );

  irq_dc_ack #(.N(N)) u_ack (
    .ack_i  (ack_i),
    .st_i   (st_reti),
    .st_o   (st_ack),
    .hit_o  (ack_hit),
    .err_o  (ack_err),
    .vec_o  (ack_vec)
  );

  irq_dc_req #(.N(N), .N_ACT(N_ACT)) u_req (
    .req_i  (req_i),
    .vec_i  (vec_in),
    .st_i   (st_ack),
    .st_o   (st_d),
    .err_o  (req_err)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(N); i++) begin
        st_q[i] <= '{en: 1'b1, rq: 1'b0, pd: 1'b0, vec: '0};
      end
      ack_vec_o <= '0;
      ack_err_o <= 1'b0;
      req_err_o <= 1'b0;
    end else begin
      st_q      <= st_d;
      ack_err_o <= ack_err;
      req_err_o <= req_err;
      if (ack_hit) ack_vec_o <= ack_vec;
    end
  end

  always_comb begin
    any_rq = 1'b0;
    for (int i = 0; i < int'(N); i++) any_rq = any_rq | st_q[i].rq;
  end
  assign irq_o = any_rq;
endmodule

// File: rtl/irq_dc_chk.sv
module irq_dc_chk #(
  parameter int unsigned N_ACT = 8
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] req_i,
  input logic        ack_i,
  input logic        irq_o,
  input logic [7:0]  ack_vec_o,
  input logic        ack_err_o,
  input logic        req_err_o
);
  localparam logic [16:0] ONE_SH   = 17'd1 << N_ACT;
  localparam logic [16:0] ACT_FULL = ONE_SH - 17'd1;
  localparam logic [15:0] ACT_MASK = ACT_FULL[15:0];

  // R7
  a_r7_err_on_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && !irq_o |=> ack_err_o);
  // R6
  a_r6_no_err_when_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && irq_o |=> !ack_err_o);
  // R7
  a_r7_vec_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_err_o |-> $stable(ack_vec_o));
  // R7
  a_r7_err_needs_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_err_o |-> $past(ack_i));
  // R8
  a_r8_irq_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !ack_i |=> irq_o);
  // R1
  a_r1_inactive_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o && ((req_i & ACT_MASK) == 16'd0) |=> !irq_o);
  // R10
  a_r10_err_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_err_o |-> $past((req_i & ACT_MASK) != 16'd0));
endmodule

bind irq_daisy_chain irq_dc_chk #(.N_ACT(N_ACT)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .ack_i     (ack_i),
  .irq_o     (irq_o),
  .ack_vec_o (ack_vec_o),
  .ack_err_o (ack_err_o),
  .req_err_o (req_err_o)
);

// File: tb/irq_daisy_chain_test.sv
`timescale 1ns/1ps
module irq_daisy_chain_test;
  localparam int MAXP = 16;
  localparam int NACT = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [15:0]  req = '0;
  logic [127:0] req_vec = '0;
  logic         ack = 1'b0;
  logic         reti = 1'b0;
  logic         irq;
  logic [7:0]   ack_vec;
  logic         ack_err;
  logic         req_err;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  bit       m_en [MAXP];
  bit       m_rq [MAXP];
  bit       m_pd [MAXP];
  bit [7:0] m_vec[MAXP];
  bit [7:0] m_avec;
  bit       m_aerr, m_rerr;

  always #5 clk = ~clk;

  irq_daisy_chain #(.N_ACT(NACT)) uut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .req_i     (req),
    .req_vec_i (req_vec),
    .ack_i     (ack),
    .reti_i    (reti),
    .irq_o     (irq),
    .ack_vec_o (ack_vec),
    .ack_err_o (ack_err),
    .req_err_o (req_err)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit m_irq();
    bit a = 1'b0;
    for (int i = 0; i < MAXP; i++) a |= m_rq[i];
    return a;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < MAXP; i++) begin
      m_en[i] = 1'b1; m_rq[i] = 1'b0; m_pd[i] = 1'b0; m_vec[i] = '0;
    end
    m_avec = '0; m_aerr = 1'b0; m_rerr = 1'b0;
  endtask

  // Expected next state per R3..R11
  task automatic model_step();
    bit fnd = 1'b0, stp = 1'b0, hit = 1'b0, msk = 1'b0;
    if (reti) begin
      for (int i = 0; i < MAXP; i++) begin
        if (!stp) begin
          m_en[i] = 1'b1;
          if (m_pd[i]) begin
            if (fnd) stp = 1'b1;
            else begin m_pd[i] = 1'b0; fnd = 1'b1; end
          end
        end
      end
    end
    m_aerr = 1'b0;
    if (ack) begin
      for (int i = 0; i < MAXP; i++) begin
        if (!hit && m_rq[i]) begin
          m_rq[i] = 1'b0; m_pd[i] = 1'b1; m_avec = m_vec[i]; hit = 1'b1;
        end
      end
      m_aerr = !hit;
    end
    m_rerr = 1'b0;
    for (int i = 0; i < NACT; i++) begin
      if (msk) m_en[i] = 1'b0;
      if (req[i] && m_en[i]) begin
        if (m_pd[i]) m_rerr = 1'b1;
        else begin
          m_en[i] = 1'b0; m_rq[i] = 1'b1; m_vec[i] = req_vec[8*i +: 8]; msk = 1'b1;
        end
      end
    end
  endtask

  task automatic cyc();
    model_step();
    @(posedge clk);
    #1;
    check("R8 irq_o", {31'd0, irq}, {31'd0, m_irq()});
    check("R6 ack_vec_o", {24'd0, ack_vec}, {24'd0, m_avec});
    check("R7 ack_err_o", {31'd0, ack_err}, {31'd0, m_aerr});
    check("R10 req_err_o", {31'd0, req_err}, {31'd0, m_rerr});
    req = '0; ack = 1'b0; reti = 1'b0;
    #3;
  endtask

  task automatic do_req(input int p, input logic [7:0] v);
    req[p] = 1'b1;
    req_vec[8*p +: 8] = v;
    cyc();
  endtask

  task automatic do_ack();  ack = 1'b1;  cyc(); endtask
  task automatic do_reti(); reti = 1'b1; cyc(); endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    #12;
    check("R2 irq_o", {31'd0, irq}, 32'd0);
    check("R2 ack_vec_o", {24'd0, ack_vec}, 32'd0);
    check("R2 ack_err_o", {31'd0, ack_err}, 32'd0);
    check("R2 req_err_o", {31'd0, req_err}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: inactive positions
    do_req(12, 8'hC1);
    check("R1 inactive", {31'd0, irq}, 32'd0);
    do_req(15, 8'hC2);
    check("R1 inactive top", {31'd0, irq}, 32'd0);

    // R4, R6, R8
    do_req(3, 8'h5A);
    check("R4 irq after accept", {31'd0, irq}, 32'd1);
    do_ack();
    check("R6 vector", {24'd0, ack_vec}, 32'h5A);
    check("R8 irq drops", {31'd0, irq}, 32'd0);

    // R3, R5: position 5 disabled by 3
    do_req(5, 8'h55);
    check("R5 lower masked", {31'd0, irq}, 32'd0);
    do_ack();
    check("R3 dropped request", {31'd0, ack_err}, 32'd1);
    check("R7 vector held", {24'd0, ack_vec}, 32'h5A);

    // nesting at position 1
    do_req(1, 8'h11);
    do_ack();
    check("R6 nested vector", {24'd0, ack_vec}, 32'h11);
    do_reti();
    // R10: position 3 enabled by scan but still pending
    do_req(3, 8'h33);
    check("R10 pending request", {31'd0, req_err}, 32'd1);
    check("R10 no irq", {31'd0, irq}, 32'd0);
    do_req(2, 8'h22);
    do_ack();
    check("R9 re-enabled 2", {24'd0, ack_vec}, 32'h22);
    do_reti();
    do_reti();
    do_req(7, 8'h77);
    do_ack();
    check("R9 full release", {24'd0, ack_vec}, 32'h77);
    do_reti();

    // R11: simultaneous requests, lower wins and masks higher
    req[6] = 1'b1; req_vec[48 +: 8] = 8'h66;
    req[2] = 1'b1; req_vec[16 +: 8] = 8'h2B;
    cyc();
    do_ack();
    check("R11 lower index wins", {24'd0, ack_vec}, 32'h2B);
    do_ack();
    check("R11 higher masked", {31'd0, ack_err}, 32'd1);
    do_reti();

    // R11: return, acknowledge and request in one cycle
    do_req(4, 8'h44);
    reti = 1'b1; ack = 1'b1; req[0] = 1'b1; req_vec[0 +: 8] = 8'h0F;
    cyc();
    check("R11 combined ack", {24'd0, ack_vec}, 32'h44);
    check("R11 combined req", {31'd0, irq}, 32'd1);

    // random interleaving
    for (int k = 0; k < 4000; k++) begin
      if (($urandom % 3) == 0) begin
        req = 16'($urandom) & 16'($urandom) & 16'($urandom);
        req_vec = {$urandom, $urandom, $urandom, $urandom};
      end
      ack  = (($urandom % 4) == 0);
      reti = (($urandom % 5) == 0);
      cyc();
    end

    finish_run();
  end
endmodule